// File: doc/BRIEF.md
# Ping-Pong Subscriber Line Serial Master

This block is the master end of a half-duplex, time-shared serial link to a group of subscriber line devices. It produces a bit clock and a frame strobe from the system clock. The strobe marks the frame boundary and also tells the slaves which way data flows. While the strobe is high, the master shifts one word of four bytes out on each port's data line. While the strobe is low, it releases the line and shifts in four bytes from the slave.

Each port carries one 64 kbit/s voice channel, a second 64 kbit/s channel, a feature-control byte that programs the slave, and a signaling byte, in both directions. A one-cycle pulse marks the end of each exchange. All ports share the strobe and the bit clock. Each port has its own data line, which is split into output, output-enable and input. With the default settings the link has eight ports, 8-bit bytes and four bytes per direction, so a frame is 64 bit slots long. The bit clock runs at the system rate divided by 2·DIV_HALF.

Top module: `pingpong_line_master`

## Requirements
- R1: While rst_n is low, line_clk and frame_strobe are 1, every line_oe bit is 0, every line_out bit is 0, up_valid is 0 and up_bytes is 0. The first system cycle after reset is the first cycle of slot 0 of a new frame.
- R2: Each bit slot lasts 2·DIV_HALF system cycles. line_clk is 1 for the first DIV_HALF cycles of a slot and 0 for the rest.
- R3: A frame has 64 slots. frame_strobe is 1 during slots 0 to 31 and 0 during slots 32 to 63. It changes only where line_clk rises.
- R4: Every line_oe bit is 1 exactly during slots 0 to 31 and 0 during slots 32 to 63.
- R5: Each port's 32-bit downstream word sits in dn_bytes[32p+31:32p] as {B1, B2, feature control, signaling}, with B1 in bits 31:24. In slot s (0 to 31), line_out[p] carries bit 31−s of that word, so the most significant bit goes first.
- R6: The downstream word is captured at the clock edge that opens slot 0, including the edge that releases reset. A change to dn_bytes later in the frame does not affect that frame.
- R7: line_in[p] is sampled at the system edge where line_clk falls in each of slots 32 to 63. The bit from slot 32+i becomes bit 31−i of the upstream word, so the order is the same as downstream.
- R8: up_valid is 1 for exactly one cycle: the first cycle of slot 0 after a completed frame. up_bytes[32p+31:32p] takes the port's new upstream word in that cycle and holds it until the next pulse.
- R9: While line_oe[p] is 0, line_out[p] equals RELEASE_LEVEL (default 0).
- R10: Ports are independent: each port's line_out and upstream word follow only that port's own dn_bytes slice and line_in bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dn_bytes | input | PORTS·32 | Downstream words, one 32-bit slice per port |
| line_in | input | PORTS | Data line read-back, one bit per port |
| line_clk | output | 1 | Shared bit clock |
| frame_strobe | output | 1 | Shared frame/direction strobe |
| line_out | output | PORTS | Data line drive value per port |
| line_oe | output | PORTS | Data line output enable per port |
| up_bytes | output | PORTS·32 | Upstream words captured in the last frame |
| up_valid | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with three ports and DIV_HALF of 2, so one frame is only 256 system cycles. This lets every slot of several consecutive frames be checked cycle by cycle against an arithmetic slot/phase model. The bench uses a distinct data pattern for each port and each frame, including all-zero and all-one words. It rewrites the downstream words in the middle of each frame to show that the capture at slot 0 holds. It also asserts reset in the middle of a frame and checks that the frame restarts from slot 0.

// File: rtl/ppl_pkg.sv
package ppl_pkg;
   // Level of the bit clock inside a bit slot.
   typedef enum logic {
      PH_HIGH = 1'b0,
      PH_LOW  = 1'b1
   } bit_phase_e;
endpackage

// File: rtl/ppl_timebase.sv
module ppl_timebase
   import ppl_pkg::*;
#(
   parameter int unsigned DIV_HALF   = 49,
   parameter int unsigned FRAME_BITS = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic line_clk,
   output logic in_down,
   output logic launch,
   output logic sample,
   output logic frame_end
);
   localparam int unsigned CW   = $clog2(DIV_HALF);
   localparam int unsigned SW   = $clog2(FRAME_BITS);
   localparam int unsigned HALF = FRAME_BITS / 2;

   generate
      if (DIV_HALF < 2) begin : g_bad_div
         $error("DIV_HALF must be at least 2");
      end
      if (FRAME_BITS < 4 || (FRAME_BITS % 2) != 0) begin : g_bad_frame
         $error("FRAME_BITS must be even and at least 4");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   bit_phase_e    ph_q;
   logic [SW-1:0] slot_q;
   logic          half_last;

   assign half_last = (cnt_q == CW'(DIV_HALF - 1));
   assign launch    = half_last && (ph_q == PH_LOW);
   assign sample    = half_last && (ph_q == PH_HIGH);
   assign frame_end = launch && (slot_q == SW'(FRAME_BITS - 1));
   assign in_down   = (slot_q < SW'(HALF));
   assign line_clk  = (ph_q == PH_HIGH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ph_q   <= PH_HIGH;
         slot_q <= '0;
      end else begin
         cnt_q <= half_last ? '0 : cnt_q + 1'b1;
         if (half_last) begin
            ph_q <= (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
         end
         if (launch) begin
            slot_q <= frame_end ? '0 : slot_q + 1'b1;
         end
      end
   end

   // R2
   clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(line_clk) |-> (cnt_q == '0));
endmodule

// File: rtl/ppl_lane.sv
module ppl_lane #(
   parameter int unsigned HALF_BITS     = 32,
   parameter int unsigned RELEASE_LEVEL = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_down,
   input  logic                 launch,
   input  logic                 sample,
   input  logic                 frame_end,
   input  logic [HALF_BITS-1:0] dn_word,
   input  logic                 line_in,
   output logic                 line_out,
   output logic                 line_oe,
   output logic [HALF_BITS-1:0] up_word
);
   logic [HALF_BITS-1:0] tx_sr;
   logic [HALF_BITS-1:0] rx_sr;

   // Downstream snapshot at frame start, then MSB-first shifting.
   always_ff @(posedge clk) begin
      if (!rst_n || frame_end) begin
         tx_sr <= dn_word;
      end else if (launch && in_down) begin
         tx_sr <= {tx_sr[HALF_BITS-2:0], 1'b0};
      end
   end

   // Upstream shifting on the falling bit-clock point, hand-off at frame end.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_sr   <= '0;
         up_word <= '0;
      end else begin
         if (sample && !in_down) begin
            rx_sr <= {rx_sr[HALF_BITS-2:0], line_in};
         end
         if (frame_end) begin
            up_word <= rx_sr;
         end
      end
   end

   assign line_oe = in_down && rst_n;

   generate
      if (RELEASE_LEVEL != 0) begin : g_rel_high
         assign line_out = line_oe ? tx_sr[HALF_BITS-1] : 1'b1;
      end else begin : g_rel_low
         assign line_out = line_oe && tx_sr[HALF_BITS-1];
      end
   endgenerate

   // R6
   snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(frame_end) && !$past(launch)) |-> $stable(tx_sr));
endmodule

// File: rtl/pingpong_line_master.sv
module pingpong_line_master #(
   parameter int unsigned PORTS         = 8,
   parameter int unsigned DIV_HALF      = 49,
   parameter int unsigned BYTE_W        = 8,
   parameter int unsigned BYTES_PER_DIR = 4,
   parameter int unsigned RELEASE_LEVEL = 0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [PORTS*BYTE_W*BYTES_PER_DIR-1:0] dn_bytes,
   input  logic [PORTS-1:0]                line_in,
   output logic                            line_clk,
   output logic                            frame_strobe,
   output logic [PORTS-1:0]                line_out,
   output logic [PORTS-1:0]                line_oe,
   output logic [PORTS*BYTE_W*BYTES_PER_DIR-1:0] up_bytes,
   output logic                            up_valid
);
   localparam int unsigned HALF_BITS  = BYTE_W * BYTES_PER_DIR;
   localparam int unsigned FRAME_BITS = 2 * HALF_BITS;

   generate
      if (PORTS < 1) begin : g_bad_ports
         $error("PORTS must be at least 1");
      end
      if (HALF_BITS < 2) begin : g_bad_half
         $error("BYTE_W * BYTES_PER_DIR must be at least 2");
      end
   endgenerate

   logic in_down, launch, sample, frame_end;

   ppl_timebase #(
      .DIV_HALF   (DIV_HALF),
      .FRAME_BITS (FRAME_BITS)
   ) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_clk  (line_clk),
      .in_down   (in_down),
      .launch    (launch),
      .sample    (sample),
      .frame_end (frame_end)
   );

   assign frame_strobe = in_down;

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_lane
         ppl_lane #(
            .HALF_BITS     (HALF_BITS),
            .RELEASE_LEVEL (RELEASE_LEVEL)
         ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_down   (in_down),
            .launch    (launch),
            .sample    (sample),
            .frame_end (frame_end),
            .dn_word   (dn_bytes[p*HALF_BITS +: HALF_BITS]),
            .line_in   (line_in[p]),
            .line_out  (line_out[p]),
            .line_oe   (line_oe[p]),
            .up_word   (up_bytes[p*HALF_BITS +: HALF_BITS])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_valid <= 1'b0;
      end else begin
         up_valid <= frame_end;
      end
   end

   // R3
   strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(frame_strobe) |-> $rose(line_clk));

   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |=> !up_valid);

   // R8
   valid_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> (frame_strobe && line_clk));

   // R8
   up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(up_bytes) |-> up_valid);
endmodule

// File: tb/pingpong_line_master_test.sv
module pingpong_line_master_test;
   localparam int P  = 3;
   localparam int D  = 2;
   localparam int W  = 32;
   localparam int FB = 64;
   localparam int F  = FB * 2 * D;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [P*W-1:0]   dn_bytes;
   logic [P-1:0]     line_in;
   logic             line_clk, frame_strobe, up_valid;
   logic [P-1:0]     line_out, line_oe;
   logic [P*W-1:0]   up_bytes;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pingpong_line_master #(
      .PORTS (P), .DIV_HALF (D), .BYTE_W (8), .BYTES_PER_DIR (4), .RELEASE_LEVEL (0)
   ) uut (
      .clk (clk), .rst_n (rst_n), .dn_bytes (dn_bytes), .line_in (line_in),
      .line_clk (line_clk), .frame_strobe (frame_strobe), .line_out (line_out),
      .line_oe (line_oe), .up_bytes (up_bytes), .up_valid (up_valid)
   );

   function automatic logic [31:0] dpat(int run, int k, int p);
      if (k == 1) return (p % 2 == 1) ? 32'hFFFF_FFFF : 32'h0000_0000;
      return (32'h9E37_79B9 * (k + 3)) ^ (32'hC2B2_AE35 * (p + 1)) ^ (32'h0100_0193 * (run + 1));
   endfunction

   function automatic logic [31:0] upat(int run, int k, int p);
      if (k == 2) return (p % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_0000;
      return (32'h85EB_CA6B * (k + 5)) ^ (32'h27D4_EB2F * (p + 2)) ^ (32'h7F4A_7C15 * (run + 1));
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_reset_state();
      // R1
      chk("R1", "line_clk", 32'(line_clk), 32'd1);
      chk("R1", "frame_strobe", 32'(frame_strobe), 32'd1);
      chk("R1", "line_oe", 32'(line_oe), 32'd0);
      chk("R1", "line_out", 32'(line_out), 32'd0);
      chk("R1", "up_valid", 32'(up_valid), 32'd0);
      for (int p = 0; p < P; p++) chk("R1", "up_bytes", up_bytes[p*W +: W], 32'd0);
   endtask

   // Runs from the first cycle after reset release up to cycle end_t.
   task automatic run_frames(int run, int end_t);
      int t = 0;
      while (t < end_t) begin
         int slot = (t / (2 * D)) % FB;
         int k    = t / F;
         bit hi   = ((t / D) % 2) == 0;
         for (int p = 0; p < P; p++) begin
            logic [31:0] u = upat(run, k, p);
            line_in[p] = (slot >= 32) ? u[63 - slot] : 1'b0;
         end
         #1;
         chk("R2", "line_clk", 32'(line_clk), 32'(hi));
         chk("R3", "frame_strobe", 32'(frame_strobe), 32'(slot < 32));
         chk("R8", "up_valid", 32'(up_valid), 32'((t % F == 0) && (k >= 1)));
         for (int p = 0; p < P; p++) begin
            logic [31:0] dw = dpat(run, k, p);
            logic [31:0] uw = (k >= 1) ? upat(run, k - 1, p) : 32'd0;
            chk("R4", "line_oe", 32'(line_oe[p]), 32'(slot < 32));
            if (slot < 32)
               chk("R5 R6 R10", "line_out", 32'(line_out[p]), 32'(dw[31 - slot]));
            else
               chk("R9", "line_out released", 32'(line_out[p]), 32'd0);
            chk("R7 R8 R10", "up_bytes", up_bytes[p*W +: W], uw);
         end
         // R6: rewrite downstream words mid-frame for the next frame
         if (t % F == 3)
            for (int p = 0; p < P; p++) dn_bytes[p*W +: W] = dpat(run, k + 1, p);
         @(posedge clk);
         t++;
         @(negedge clk);
      end
   endtask

   initial begin
      rst_n   = 1'b0;
      line_in = '0;
      for (int p = 0; p < P; p++) dn_bytes[p*W +: W] = dpat(0, 0, p);
      repeat (4) @(negedge clk);
      chk_reset_state();
      rst_n = 1'b1;
      run_frames(0, 3 * F + F / 2 + 7);
      // R1: reset in mid-frame restarts at slot 0
      rst_n = 1'b0;
      for (int p = 0; p < P; p++) dn_bytes[p*W +: W] = dpat(1, 0, p);
      repeat (3) @(negedge clk);
      chk_reset_state();
      rst_n = 1'b1;
      run_frames(1, 3 * F + 5);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule